// File: doc/BRIEF.md
# Configuration Cycle Access Sequencer

This block turns a configuration-space access request into the window register traffic a host bridge needs to reach that space. A request carries a bus number, a device/function number and a register offset. From these the block forms the configuration address and a map value, then borrows outbound window 1 for configuration space. To do this it first widens window 0 so that it covers the region window 1 normally serves. It then points window 1 at the 16 MB configuration region and loads the map value. Once the access has been carried out, it restores window 1 to prefetchable memory and shrinks window 0 back to its normal size.

The data transfer itself is outside this block. It is shown as a held access address and an externally supplied completion pulse. Register writes leave through a single write port with a valid/ready handshake.

The controller moves through these states: `S_IDLE`, `S_GROW0`, `S_CFG1`, `S_MAP1`, `S_ACCESS`, `S_REST1`, `S_REMAP1`, `S_SHRINK0` and `S_FINISH`. The transitions are as follows:
- `S_IDLE` goes to `S_GROW0` when a request is taken.
- Each write state advances to the next state when its write is accepted: `S_GROW0` to `S_CFG1` to `S_MAP1` to `S_ACCESS`, and then `S_REST1` to `S_REMAP1` to `S_SHRINK0` to `S_FINISH`.
- `S_ACCESS` goes to `S_REST1` on the completion pulse.
- `S_FINISH` returns to `S_IDLE` unconditionally after one cycle.

Top module: `cfg_access_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `wr_valid`, `acc_valid` and `done` are all low.
- R2: A request present while `busy` is low is taken, and `busy` is high on the next cycle. A request present while `busy` is high has no effect: it does not change the current sequence's addresses or data, and it starts no new sequence after `done`.
- R3: The remap writes come first, in this order. Select code 0 (window 0 base word) carries the non-prefetchable base bits 31..20, size code 9 (512 MB) in bits 7..4 and enable in bit 0. Select code 1 (window 1 base word) carries the configuration base bits 31..20, size code 4 (16 MB) and enable. Select code 2 (map 1 word) carries the configuration map value.
- R4: On bus 0, with slot = devfn[7:3] of 12 or less, the address holds the function devfn[2:0] in bits 10..8 and a single set bit at position slot+11. The map value is 0x000A, which is type 5 in bits 3..1 with pass-through bit 0 clear.
- R5: On bus 0, with a slot above 12, the address holds only the function bits. The map value is 0x000A with one extra bit set at position slot-5 of the 16-bit map. Slots 21 to 31 therefore add no bit.
- R6: On any bus other than 0, the address is bus<<16 | devfn<<8 and the map value is 0x000B.
- R7: After the third remap write, `acc_valid` is held with `acc_addr` = configuration base + address + offset until `acc_done`. An `acc_done` in any other state has no effect.
- R8: The restore writes come next, in this order. Select code 1 carries the prefetchable base, size code 8 (256 MB), prefetch bit 3 and enable. Select code 2 carries the prefetchable bus address bits 31..20 in bits 15..4 and memory type 3 in bits 3..1. Select code 0 carries the non-prefetchable base, size code 8 and enable.
- R9: A write stays valid, with its select and data unchanged, until `wr_ready` is seen. The next write or the access phase begins only after that. At most one of `wr_valid`, `acc_valid` and `done` is high in any cycle.
- R10: `done` pulses for one cycle after the last restore write is accepted, and `busy` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DEVFN_W | Device (upper bits) and function (low 3 bits) |
| req_offset | input | OFF_W | Configuration register offset |
| busy | output | 1 | Sequence in progress; requests are refused |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register write accepted |
| wr_sel | output | 2 | 0 window 0 base, 1 window 1 base, 2 map 1 |
| wr_data | output | 32 | Register write value |
| acc_valid | output | 1 | Configuration access may proceed |
| acc_addr | output | 32 | Local address of the configuration access |
| acc_done | input | 1 | External access completed |

## Verification
Two events can meet in one cycle: the completion pulse of one sequence and the arrival of a fresh request. The bench provokes this by raising a junk request in exactly the cycle where `done` is seen, and also at random points inside the sequence. It judges the outcome by checking that the current sequence's writes and access address keep their original values, that `busy` drops, and that no write appears in the cycles after `done`. Stray `wr_ready` and `acc_done` pulses outside their phases are mixed in as well, so that a write accepted early would show up as a wrong event order.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int DATA_W = 32;

    localparam logic [3:0] SZ_16M  = 4'd4;
    localparam logic [3:0] SZ_256M = 4'd8;
    localparam logic [3:0] SZ_512M = 4'd9;

    localparam logic [2:0] MAP_TYPE_MEM = 3'd3;
    localparam logic [2:0] MAP_TYPE_CFG = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GROW0,
        S_CFG1,
        S_MAP1,
        S_ACCESS,
        S_REST1,
        S_REMAP1,
        S_SHRINK0,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_WIN0 = 2'd0,
        SEL_WIN1 = 2'd1,
        SEL_MAP1 = 2'd2
    } reg_sel_t;

    // Window base word: base[31:20], size code [7:4], prefetch [3], enable [0].
    function automatic logic [DATA_W-1:0] win_word(input logic [DATA_W-1:0] base,
                                                   input logic [3:0] code,
                                                   input logic pf);
        return {base[31:20], 12'h000, code, pf, 2'b00, 1'b1};
    endfunction

endpackage

// File: rtl/cfgseq_addr_gen.sv
module cfgseq_addr_gen #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int MAP_W   = 16,
    parameter int SPLIT   = 12
) (
    input  logic [BUS_W-1:0]           bus,
    input  logic [DEVFN_W-1:0]         devfn,
    output logic [cfgseq_pkg::DATA_W-1:0] cfg_addr,
    output logic [MAP_W-1:0]           map_val
);
    import cfgseq_pkg::*;

    localparam int SLOT_W = DEVFN_W - 3;
    localparam int NSLOT  = 1 << SLOT_W;
    localparam int ADR_SHIFT = 11;
    localparam int MAP_SHIFT = 5;

    logic [SLOT_W-1:0] slot;
    logic [2:0]        func;
    logic [NSLOT-1:0]  hit;
    logic [DATA_W-1:0] addr_hot;
    logic [MAP_W-1:0]  map_hot;

    assign slot = devfn[DEVFN_W-1:3];
    assign func = devfn[2:0];

    for (genvar s = 0; s < NSLOT; s++) begin : g_hit
        assign hit[s] = (slot == SLOT_W'(s));
    end

    // Low slots select a device through an address line.
    for (genvar b = 0; b < DATA_W; b++) begin : g_abit
        if (b >= ADR_SHIFT && b - ADR_SHIFT <= SPLIT && b - ADR_SHIFT < NSLOT) begin : g_on
            assign addr_hot[b] = hit[b - ADR_SHIFT];
        end else begin : g_off
            assign addr_hot[b] = 1'b0;
        end
    end

    // High slots select a device through the map word instead.
    for (genvar b = 0; b < MAP_W; b++) begin : g_mbit
        if (b + MAP_SHIFT > SPLIT && b + MAP_SHIFT < NSLOT) begin : g_on
            assign map_hot[b] = hit[b + MAP_SHIFT];
        end else begin : g_off
            assign map_hot[b] = 1'b0;
        end
    end

    always_comb begin
        if (bus == '0) begin
            cfg_addr = addr_hot | (DATA_W'(func) << 8);
            map_val  = map_hot | MAP_W'({MAP_TYPE_CFG, 1'b0});
        end else begin
            cfg_addr = (DATA_W'(bus) << 16) | (DATA_W'(devfn) << 8);
            map_val  = MAP_W'({MAP_TYPE_CFG, 1'b1});
        end
    end

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       wr_ready,
    input  logic       acc_done,
    output logic       busy,
    output logic       wr_valid,
    output logic [1:0] wr_sel,
    output logic       restore_phase,
    output logic       acc_valid,
    output logic       done
);
    import cfgseq_pkg::*;

    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_GROW0;
            S_GROW0:   if (wr_ready)  state_nx = S_CFG1;
            S_CFG1:    if (wr_ready)  state_nx = S_MAP1;
            S_MAP1:    if (wr_ready)  state_nx = S_ACCESS;
            S_ACCESS:  if (acc_done)  state_nx = S_REST1;
            S_REST1:   if (wr_ready)  state_nx = S_REMAP1;
            S_REMAP1:  if (wr_ready)  state_nx = S_SHRINK0;
            S_SHRINK0: if (wr_ready)  state_nx = S_FINISH;
            S_FINISH:                 state_nx = S_IDLE;
            default:                  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy          = (state != S_IDLE);
        wr_valid      = 1'b0;
        wr_sel        = SEL_WIN0;
        restore_phase = 1'b0;
        acc_valid     = 1'b0;
        done          = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_GROW0:   begin wr_valid = 1'b1; wr_sel = SEL_WIN0; end
            S_CFG1:    begin wr_valid = 1'b1; wr_sel = SEL_WIN1; end
            S_MAP1:    begin wr_valid = 1'b1; wr_sel = SEL_MAP1; end
            S_ACCESS:  acc_valid = 1'b1;
            S_REST1:   begin wr_valid = 1'b1; wr_sel = SEL_WIN1; restore_phase = 1'b1; end
            S_REMAP1:  begin wr_valid = 1'b1; wr_sel = SEL_MAP1; restore_phase = 1'b1; end
            S_SHRINK0: begin wr_valid = 1'b1; wr_sel = SEL_WIN0; restore_phase = 1'b1; end
            S_FINISH:  done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq #(
    parameter logic [31:0] NP_WIN_BASE  = 32'h4000_0000,
    parameter logic [31:0] PF_WIN_BASE  = 32'h5000_0000,
    parameter logic [31:0] PF_BUS_ADDR  = 32'h5000_0000,
    parameter logic [31:0] CFG_WIN_BASE = 32'h6100_0000,
    parameter int          BUS_W        = 8,
    parameter int          DEVFN_W      = 8,
    parameter int          OFF_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_offset,
    output logic               busy,
    output logic               done,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [1:0]         wr_sel,
    output logic [31:0]        wr_data,
    output logic               acc_valid,
    output logic [31:0]        acc_addr,
    input  logic               acc_done
);
    import cfgseq_pkg::*;

    localparam int MAP_W = 16;

    logic [BUS_W-1:0]   bus_q;
    logic [DEVFN_W-1:0] devfn_q;
    logic [OFF_W-1:0]   off_q;
    logic [DATA_W-1:0]  cfg_addr;
    logic [MAP_W-1:0]   map_val;
    logic               restore_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q   <= '0;
            devfn_q <= '0;
            off_q   <= '0;
        end else if (req_valid && !busy) begin
            bus_q   <= req_bus;
            devfn_q <= req_devfn;
            off_q   <= req_offset;
        end
    end

    cfgseq_addr_gen #(
        .BUS_W   (BUS_W),
        .DEVFN_W (DEVFN_W),
        .MAP_W   (MAP_W),
        .SPLIT   (12)
    ) u_addr (
        .bus      (bus_q),
        .devfn    (devfn_q),
        .cfg_addr (cfg_addr),
        .map_val  (map_val)
    );

    cfgseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .wr_ready      (wr_ready),
        .acc_done      (acc_done),
        .busy          (busy),
        .wr_valid      (wr_valid),
        .wr_sel        (wr_sel),
        .restore_phase (restore_phase),
        .acc_valid     (acc_valid),
        .done          (done)
    );

    always_comb begin
        unique case ({restore_phase, wr_sel})
            {1'b0, SEL_WIN0}: wr_data = win_word(NP_WIN_BASE, SZ_512M, 1'b0);
            {1'b0, SEL_WIN1}: wr_data = win_word(CFG_WIN_BASE, SZ_16M, 1'b0);
            {1'b0, SEL_MAP1}: wr_data = DATA_W'(map_val);
            {1'b1, SEL_WIN1}: wr_data = win_word(PF_WIN_BASE, SZ_256M, 1'b1);
            {1'b1, SEL_MAP1}: wr_data = {16'h0000, PF_BUS_ADDR[31:20], MAP_TYPE_MEM, 1'b0};
            {1'b1, SEL_WIN0}: wr_data = win_word(NP_WIN_BASE, SZ_256M, 1'b0);
            default:          wr_data = '0;
        endcase
    end

    assign acc_addr = CFG_WIN_BASE + cfg_addr + DATA_W'(off_q);

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic        acc_done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !acc_valid && !done));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_access_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_done) |=> (acc_valid && $stable(acc_addr)));

    assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_sel) && $stable(wr_data)));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, acc_valid, done}));

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind cfg_access_seq cfgseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_done  (acc_done)
);

// File: tb/cfg_access_seq_bench.sv
`timescale 1ns/1ps
module cfg_access_seq_bench;

    localparam logic [31:0] NPB = 32'h4000_0000;
    localparam logic [31:0] PFB = 32'h5000_0000;
    localparam logic [31:0] PFA = 32'h5000_0000;
    localparam logic [31:0] CFB = 32'h6100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0, req_devfn = '0, req_offset = '0;
    logic        busy, done, wr_valid, acc_valid;
    logic        wr_ready = 1'b0, acc_done = 1'b0;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data, acc_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_access_seq u_cfg_access_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_offset(req_offset), .busy(busy), .done(done),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_done(acc_done)
    );

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wword(input logic [31:0] b, input logic [3:0] c, input logic p);
        return (b & 32'hFFF0_0000) | (32'(c) << 4) | (32'(p) << 3) | 32'h1;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [7:0] bus, input logic [7:0] devfn);
        int slot = int'(devfn >> 3);
        logic [31:0] a;
        if (bus != 0) return (32'(bus) << 16) | (32'(devfn) << 8);
        a = 32'(devfn & 8'h07) << 8;
        if (slot <= 12) a = a | (32'h1 << (slot + 11));
        return a;
    endfunction

    function automatic logic [31:0] exp_map(input logic [7:0] bus, input logic [7:0] devfn);
        int slot = int'(devfn >> 3);
        logic [31:0] m;
        if (bus != 0) return 32'h0000_000B;
        m = 32'h0000_000A;
        if (slot > 12) m = m | ((32'h1 << (slot - 5)) & 32'h0000_FFFF);
        return m;
    endfunction

    task automatic run_txn(input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [7:0] off, input bit noisy, input string tag);
        int          ev_kind [16];
        logic [31:0] ev_data [16];
        int          exp_kind [7];
        logic [31:0] exp_data [7];
        int          n_ev = 0;
        bit          seen_done = 0;
        bit          pend = 0;
        logic [1:0]  p_sel = '0;
        logic [31:0] p_data = '0;
        logic [31:0] ea = exp_addr(bus, devfn);
        exp_kind = '{0, 1, 2, 3, 1, 2, 0};
        exp_data[0] = wword(NPB, 4'd9, 1'b0);
        exp_data[1] = wword(CFB, 4'd4, 1'b0);
        exp_data[2] = exp_map(bus, devfn);
        exp_data[3] = CFB + ea + 32'(off);
        exp_data[4] = wword(PFB, 4'd8, 1'b1);
        exp_data[5] = {16'h0, PFA[31:20], 4'b0110};
        exp_data[6] = wword(NPB, 4'd8, 1'b0);

        @(negedge clk);
        req_valid = 1; req_bus = bus; req_devfn = devfn; req_offset = off;
        @(negedge clk);
        req_valid = 0;
        check({"R2 busy after request ", tag}, busy === 1'b1, 32'(busy), 32'h1);

        for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
            if (pend)
                check({"R9 write held ", tag}, wr_valid && wr_sel == p_sel && wr_data == p_data,
                      wr_data, p_data);
            if (done) seen_done = 1;
            if (wr_valid) begin
                wr_ready = ($urandom % 3) != 0;
                pend = !wr_ready; p_sel = wr_sel; p_data = wr_data;
                if (wr_ready && n_ev < 16) begin
                    ev_kind[n_ev] = int'(wr_sel); ev_data[n_ev] = wr_data; n_ev++;
                end
            end else begin
                pend = 0;
                wr_ready = noisy ? 1'($urandom % 2) : 1'b0;
            end
            if (acc_valid) begin
                acc_done = ($urandom % 4) == 0;
                if (acc_done && n_ev < 16) begin
                    ev_kind[n_ev] = 3; ev_data[n_ev] = acc_addr; n_ev++;
                end
            end else begin
                acc_done = noisy ? 1'($urandom % 2) : 1'b0;
            end
            req_valid = noisy && (($urandom % 3) == 0 || done);
            req_bus = 8'($urandom); req_devfn = 8'($urandom); req_offset = 8'($urandom);
            if (!seen_done) @(negedge clk);
        end
        check({"R10 done seen ", tag}, seen_done, 32'(seen_done), 32'h1);
        @(negedge clk);
        req_valid = 0; wr_ready = 0; acc_done = 0;
        check({"R10 busy low after done ", tag}, busy === 1'b0, 32'(busy), 32'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check({"R2 no sequence after ignored request ", tag}, !busy && !wr_valid,
                  32'(wr_valid), 32'h0);
        end
        check({"R9 event count ", tag}, n_ev == 7, 32'(n_ev), 32'd7);
        for (int i = 0; i < 7 && i < n_ev; i++) begin
            string r = (i < 3) ? "R3 remap" : (i == 3) ? "R7 access" : "R8 restore";
            check({r, " kind ", tag}, ev_kind[i] == exp_kind[i], 32'(ev_kind[i]), 32'(exp_kind[i]));
            check({r, " value ", tag}, ev_data[i] == exp_data[i], ev_data[i], exp_data[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset idle", !busy && !wr_valid && !acc_valid && !done, 32'(busy), 32'h0);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle after reset", !busy && !wr_valid && !acc_valid && !done, 32'(busy), 32'h0);

        run_txn(8'd0, {5'd0,  3'd0}, 8'h00, 0, "R4 slot0");
        run_txn(8'd0, {5'd12, 3'd7}, 8'hFC, 0, "R4 slot12");
        run_txn(8'd0, {5'd13, 3'd2}, 8'h10, 1, "R5 slot13");
        run_txn(8'd0, {5'd20, 3'd1}, 8'h04, 0, "R5 slot20");
        run_txn(8'd0, {5'd21, 3'd0}, 8'h08, 1, "R5 slot21");
        run_txn(8'd0, {5'd31, 3'd5}, 8'h3C, 0, "R5 slot31");
        run_txn(8'd1, 8'hFF,         8'h40, 1, "R6 bus1");
        run_txn(8'hFF, 8'h00,        8'hFF, 0, "R6 bus255");
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b = (($urandom % 2) == 0) ? 8'd0 : 8'($urandom);
            run_txn(b, 8'($urandom), 8'($urandom), 1'($urandom % 2), "R4 R5 R6 random");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule